// File: doc/BRIEF.md
# Upstream Bus Request Controller

This block decides when a bridge asks an external arbiter for ownership of a shared parallel bus so that it can forward transactions that are waiting in its upstream queues. It watches a count of transactions that have been completely queued, the active-low grant from the arbiter, and the termination status that the bus master engine reports. From these it produces the active-low request line, a one-cycle start pulse that tells the master engine to begin a transaction, and a park signal that tells the datapath to hold the address/data, command/byte-enable and parity lines at valid levels.

After the target ends an attempt with a retry, a disconnect or an abort, the block withdraws its request for a fixed back-off window before it competes again. When the arbiter grants the bus while no request is out, the bus is parked here. If work then arrives, the transaction starts without waiting for a request/grant round trip.

All outputs come from registers. Inputs are sampled on the rising clock edge, and each output reflects the inputs sampled at the previous edge.

Top module: `upreq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no other stimulus, req_n is 1, start_o is 0 and park_o is 0.
- R2: req_n is 0 in the cycle after an edge that samples queued_cnt greater than zero with no back-off running. It is 1 in the cycle after an edge that samples queued_cnt equal to zero. A count of zero means that no transaction is fully queued, so the request never goes out for partly queued work.
- R3: A termination sampled at an edge keeps req_n at 1 for exactly the next BACKOFF_CYC cycles (default 2), even when work is queued and grant is low. req_n returns to 0 in the cycle after that if queued_cnt is still nonzero.
- R4: term_retry, term_disc and term_abort each start the same back-off, and they act the same when asserted together.
- R5: start_o is 1 for the cycle after an edge where req_n is 0, gnt_n is 0 and queued_cnt is nonzero, provided no termination is sampled and no back-off is running at that edge.
- R6: park_o is 1 in the cycle after an edge that samples req_n at 1 and gnt_n at 0. It is 0 after any other edge.
- R7: When park_o is 1 at an edge, that edge samples queued_cnt nonzero, and no back-off is running, start_o is 1 in the next cycle. This holds even though req_n was 1, because grant was present on the previous cycle.
- R8: start_o stays 0 while a back-off is running, whatever the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| queued_cnt | input | CNT_W | Number of upstream transactions that are completely queued |
| gnt_n | input | 1 | Active-low grant from the external arbiter |
| term_retry | input | 1 | Master engine saw a target retry |
| term_disc | input | 1 | Master engine saw a target disconnect |
| term_abort | input | 1 | Master engine saw a target abort |
| req_n | output | 1 | Active-low bus request |
| start_o | output | 1 | One-cycle pulse telling the master engine to begin |
| park_o | output | 1 | Datapath drives address/data, command/byte-enable and parity to valid levels |

## Verification
The hardest case to reach is a start from a parked bus while the request is still deasserted, and in particular the one that falls on the last cycle of a back-off window. To get there, the stimulus holds grant low through a termination, so parking is re-established while the request is withdrawn. Work is then kept queued, so the first edge after the window starts the transaction through the parked path. Other sequences raise the queued count from zero while grant is already low, and alternate the three termination kinds between bursts of granted cycles.

// File: rtl/upreq_pkg.sv
package upreq_pkg;
  // width of a counter able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/upreq_backoff.sv
module upreq_backoff
  import upreq_pkg::*;
#(
  parameter int unsigned BACKOFF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic term_i,
  output logic clear_next_o,   // no back-off after this edge
  output logic busy_o          // back-off running now
);
  localparam int unsigned BW = cnt_width(BACKOFF_CYC);
  localparam logic [BW-1:0] LOAD = BW'(BACKOFF_CYC);

  logic [BW-1:0] bo_q, bo_d;
  logic          bo_en;

  always_comb begin
    bo_en = term_i || (bo_q != '0);
    if (term_i)
      bo_d = LOAD;
    else if (bo_q != '0)
      bo_d = bo_q - 1'b1;
    else
      bo_d = bo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bo_q <= '0;
    else if (bo_en)
      bo_q <= bo_d;
  end

  assign clear_next_o = (bo_d == '0);
  assign busy_o       = (bo_q != '0);

  // R3
  bo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_q <= LOAD);

  // R3
  bo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_i |=> (bo_q == LOAD));
endmodule

// File: rtl/upreq_park.sv
module upreq_park (
  input  logic clk,
  input  logic rst_n,
  input  logic req_on_i,   // request currently driven
  input  logic gnt_i,      // grant sampled this edge
  output logic park_o
);
  logic park_q, park_d;

  always_comb begin
    park_d = gnt_i && !req_on_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      park_q <= 1'b0;
    else
      park_q <= park_d;
  end

  assign park_o = park_q;

  // R6
  park_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |-> $past(gnt_i && !req_on_i));
endmodule

// File: rtl/upreq_ctrl.sv
module upreq_ctrl #(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned BACKOFF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] queued_cnt,
  input  logic             gnt_n,
  input  logic             term_retry,
  input  logic             term_disc,
  input  logic             term_abort,
  output logic             req_n,
  output logic             start_o,
  output logic             park_o
);
  logic have_work, term_any, gnt_on;
  logic bo_clear_next, bo_busy;
  logic req_on_q, req_on_d;
  logic start_q, start_d;
  logic parked;

  assign have_work = (queued_cnt != '0);
  assign term_any  = term_retry | term_disc | term_abort;
  assign gnt_on    = !gnt_n;

  upreq_backoff #(.BACKOFF_CYC(BACKOFF_CYC)) u_backoff (
    .clk          (clk),
    .rst_n        (rst_n),
    .term_i       (term_any),
    .clear_next_o (bo_clear_next),
    .busy_o       (bo_busy)
  );

  upreq_park u_park (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_on_i (req_on_q),
    .gnt_i    (gnt_on),
    .park_o   (parked)
  );

  always_comb begin
    req_on_d = have_work && bo_clear_next;
    start_d  = have_work && bo_clear_next &&
               ((req_on_q && gnt_on) || parked);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_on_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      req_on_q <= req_on_d;
      start_q  <= start_d;
    end
  end

  assign req_n   = !req_on_q;
  assign start_o = start_q;
  assign park_o  = parked;

  // R2
  req_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> $past(queued_cnt != '0));

  // R3
  req_off_in_bo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_busy |-> req_n);

  // R4
  term_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_any |=> req_n);

  // R8
  no_start_bo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_busy |-> !start_o);

  // R5
  start_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(queued_cnt != '0));
endmodule

// File: tb/upreq_ctrl_test.sv
module upreq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int BO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] queued_cnt = '0;
  logic gnt_n = 1'b1;
  logic term_retry = 1'b0, term_disc = 1'b0, term_abort = 1'b0;
  logic req_n, start_o, park_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  req_n;
    logic  start;
    logic  park;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // reference state, derived from the requirements
  bit m_req, m_start, m_park;
  int m_bo;

  always #(CLK_PERIOD/2) clk = ~clk;

  upreq_ctrl #(.CNT_W(CNT_W), .BACKOFF_CYC(BO)) uut (
    .clk(clk), .rst_n(rst_n), .queued_cnt(queued_cnt), .gnt_n(gnt_n),
    .term_retry(term_retry), .term_disc(term_disc), .term_abort(term_abort),
    .req_n(req_n), .start_o(start_o), .park_o(park_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected outcome
  task automatic drive(input int p, input bit g_n, input bit tr, input bit td,
                       input bit ta, input string tag);
    bit t, g, work;
    int bo_n;
    exp_t e;
    @(negedge clk);
    queued_cnt = p[CNT_W-1:0];
    gnt_n = g_n; term_retry = tr; term_disc = td; term_abort = ta;
    t = tr | td | ta;
    g = !g_n;
    work = (p != 0);
    bo_n = t ? BO : ((m_bo > 0) ? m_bo - 1 : 0);
    m_start = work && (bo_n == 0) && ((m_req && g) || m_park);
    m_park  = !m_req && g;
    m_req   = work && (bo_n == 0);
    m_bo    = bo_n;
    e.req_n = !m_req; e.start = m_start; e.park = m_park; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(req_n,   e.req_n, {e.tag, " req_n"});
      chk(start_o, e.start, {e.tag, " start_o"});
      chk(park_o,  e.park,  {e.tag, " park_o"});
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_req = 0; m_start = 0; m_park = 0; m_bo = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(req_n, 1'b1, "R1 reset req_n");
    chk(start_o, 1'b0, "R1 reset start_o");
    chk(park_o, 1'b0, "R1 reset park_o");
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 1, 0, 0, 0, "R1 idle");
    drive(0, 1, 0, 0, 0, "R2 no work");
    // park, then a parked start
    drive(0, 0, 0, 0, 0, "R6 park on grant");
    drive(3, 0, 0, 0, 0, "R7 parked start");
    drive(3, 0, 0, 0, 0, "R5 granted start");
    drive(3, 1, 0, 0, 0, "R2 req held");
    drive(3, 1, 0, 0, 0, "R2 req held no grant");
    // retry with grant held low through back-off
    drive(3, 0, 1, 0, 0, "R3 retry");
    drive(3, 0, 0, 0, 0, "R8 back-off grant");
    drive(3, 0, 0, 0, 0, "R7 exit back-off parked");
    drive(3, 0, 0, 0, 0, "R3 req back");
    // disconnect without grant
    drive(2, 1, 0, 1, 0, "R4 disconnect");
    drive(2, 1, 0, 0, 0, "R3 window 2");
    drive(2, 1, 0, 0, 0, "R3 reassert");
    drive(2, 0, 0, 0, 0, "R5 start");
    // abort
    drive(2, 1, 0, 0, 1, "R4 abort");
    drive(2, 0, 0, 0, 0, "R8 no start");
    drive(2, 1, 0, 0, 0, "R3 reassert abort");
    // all three together
    drive(1, 0, 1, 1, 1, "R4 all terms");
    drive(1, 1, 0, 0, 0, "R3 hold");
    drive(1, 1, 0, 0, 0, "R3 back");
    // work drains
    drive(0, 1, 0, 0, 0, "R2 drain");
    drive(0, 0, 0, 0, 0, "R6 park again");
    drive(0, 0, 0, 0, 0, "R6 park hold");
    drive(0, 1, 0, 0, 0, "R6 park drop");
    // varied pattern
    for (int i = 0; i < 40; i++)
      drive((i % 5 == 0) ? 0 : (i % 3) + 1, (i % 4) == 1, (i % 11) == 7,
            (i % 13) == 4, (i % 17) == 9, "R5 mixed");
    drive(0, 1, 0, 0, 0, "R2 final");
    repeat (2) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule